// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block scans a raster. A pixel counter and a line counter run on the pixel clock. From them, and from four 32-bit timing words, the block derives an active-picture flag and the horizontal and vertical sync pulses. The timing words come in through a simple write port: a select code picks the word and a data bus carries its value. Each sync output has its own programmable polarity. Three control inputs can independently force the active flag off, or either sync to its idle level.

After reset the generator is halted with all timing words at zero. While halted, every write goes straight into the live timing set. Scanning begins once each of the four words has been written at least once. From then on, writes are collected in a pending set. The pending set replaces the live set on the clock edge that ends a frame, so the live timing never changes in mid-frame.

A small load sequencer governs this behaviour. Its states are HALT, RUN and RUN_PEND. The transitions are:
- HALT to RUN, when the fourth distinct word has been written.
- RUN to RUN_PEND, on a write that does not fall on a frame end.
- RUN_PEND to RUN, at the frame end, with a commit.
- RUN to RUN with an immediate commit, when a write falls on a frame end.

Top module: `crtc_timing_gen`

## Requirements
- R1: After synchronous reset the following are all zero: pixel counter, line counter, active flag, hsync and vsync. All timing words are cleared and the generator is halted.
- R2: While halted, a write lands directly in the live timing word and both counters stay at zero. Scanning starts once each select code 0, 1, 2 and 3 has been written at least once. In the cycle after that fourth write the pixel counter reads 0, and it then advances by one per clock. Rewriting a word does not count twice.
- R3: Word at select 0 holds the line length T in bits [9:0] and the active width A in bits [24:16]. Both are 8-pixel characters minus one. The pixel counter runs from 0 to 8*(T+1)-1 and then wraps to 0.
- R4: Word at select 2 holds the total lines minus one (V) in bits [15:0] and the active lines minus one (L) in bits [31:16]. The line counter increments when the pixel counter wraps, and wraps to 0 after line V.
- R5: The active flag is high exactly when all three hold: the pixel counter is at most 8*(A+1)-1, the line counter is at most L, and display-off is low.
- R6: Word at select 1 holds the hsync start S in pixels in bits [12:0] and the width W in bits [21:16]. Bit 23 set selects active-low polarity. The pulse is asserted while S <= pixel < S+W, and otherwise held at the idle level. A width of 0 never asserts.
- R7: Word at select 3 holds the vsync start minus one (F) in bits [11:0] and the width in lines (W) in bits [20:16]. Bit 23 set selects active-low polarity. The pulse is asserted while F <= line < F+W.
- R8: Each control input acts in the same cycle and leaves the counters unchanged. hsync-off holds hsync at its idle level. vsync-off holds vsync at its idle level. display-off holds the active flag low.
- R9: While scanning, writes do not alter the live timing until the edge on which both counters are at their last values. On that edge every pending word is committed, including a write captured on that same edge. When one select is written several times, the last value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Timing word write strobe |
| wr_sel | input | 2 | Timing word select code |
| wr_data | input | 32 | Timing word value |
| display_off | input | 1 | Forces the active flag low |
| hsync_off | input | 1 | Holds hsync at its idle level |
| vsync_off | input | 1 | Holds vsync at its idle level |
| pix_x | output | 13 | Pixel counter |
| line_y | output | 16 | Line counter |
| de | output | 1 | Active-picture flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
Several properties are checked on every cycle against the live timing:
- counters stay at zero while halted;
- the pixel counter steps and wraps at the programmed line end;
- the line counter steps and wraps at the frame end;
- the active flag is low beyond the active width;
- the forced idle levels hold under the control inputs;
- the live timing is held steady everywhere except at the frame-end edge.

Other behaviours can only be shown by the bench scenarios, which compare every output against an independent cycle model:
- the exact bit positions of each field;
- where the sync windows fall and which polarity they take;
- that scanning starts only after the fourth distinct word;
- last-write-wins among pending writes;
- that a write captured on the frame-end edge is committed with that frame.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
    localparam int NUM_WORDS  = 4;
    localparam int SEL_W      = $clog2(NUM_WORDS);
    localparam int WORD_W     = 32;
    localparam int CHAR_SHIFT = 3;

    localparam int HTOT_W = 10;
    localparam int HACT_W = 9;
    localparam int HSS_W  = 13;
    localparam int HSW_W  = 6;
    localparam int VT_W   = 16;
    localparam int VSS_W  = 12;
    localparam int VSW_W  = 5;

    localparam int PIX_W  = HTOT_W + CHAR_SHIFT;
    localparam int LINE_W = VT_W;

    localparam int HTOT_LSB = 0;
    localparam int HACT_LSB = 16;
    localparam int HSS_LSB  = 0;
    localparam int HSW_LSB  = 16;
    localparam int VT_LSB   = 0;
    localparam int VACT_LSB = 16;
    localparam int VSS_LSB  = 0;
    localparam int VSW_LSB  = 16;
    localparam int POL_BIT  = 23;

    localparam int SEL_HTIME = 0;
    localparam int SEL_HSYNC = 1;
    localparam int SEL_VTIME = 2;
    localparam int SEL_VSYNC = 3;

    typedef struct packed {
        logic [HTOT_W-1:0] htot_ch;
        logic [HACT_W-1:0] hact_ch;
        logic [HSS_W-1:0]  hs_start;
        logic [HSW_W-1:0]  hs_wid;
        logic              hs_neg;
        logic [VT_W-1:0]   vtot_m1;
        logic [VT_W-1:0]   vact_m1;
        logic [VSS_W-1:0]  vs_start_m1;
        logic [VSW_W-1:0]  vs_wid;
        logic              vs_neg;
    } timing_t;

    typedef enum logic [1:0] {
        ST_HALT     = 2'd0,
        ST_RUN      = 2'd1,
        ST_RUN_PEND = 2'd2
    } gen_state_e;

    function automatic timing_t unpack_timing(input logic [NUM_WORDS-1:0][WORD_W-1:0] w);
        timing_t t;
        t.htot_ch     = w[SEL_HTIME][HTOT_LSB +: HTOT_W];
        t.hact_ch     = w[SEL_HTIME][HACT_LSB +: HACT_W];
        t.hs_start    = w[SEL_HSYNC][HSS_LSB +: HSS_W];
        t.hs_wid      = w[SEL_HSYNC][HSW_LSB +: HSW_W];
        t.hs_neg      = w[SEL_HSYNC][POL_BIT];
        t.vtot_m1     = w[SEL_VTIME][VT_LSB +: VT_W];
        t.vact_m1     = w[SEL_VTIME][VACT_LSB +: VT_W];
        t.vs_start_m1 = w[SEL_VSYNC][VSS_LSB +: VSS_W];
        t.vs_wid      = w[SEL_VSYNC][VSW_LSB +: VSW_W];
        t.vs_neg      = w[SEL_VSYNC][POL_BIT];
        return t;
    endfunction
endpackage

// File: rtl/crtc_load_fsm.sv
module crtc_load_fsm
    import crtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             frame_end,
    output logic             running,
    output logic             direct_wr,
    output logic             commit
);
    gen_state_e           state_q, state_d;
    logic [NUM_WORDS-1:0] loaded_q, loaded_d, sel_hot;

    always_comb sel_hot = wr_en ? (NUM_WORDS'(1) << wr_sel) : '0;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HALT;
            loaded_q <= '0;
        end else begin
            state_q  <= state_d;
            loaded_q <= loaded_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        loaded_d = loaded_q;
        unique case (state_q)
            ST_HALT: begin
                loaded_d = loaded_q | sel_hot;
                if (&loaded_d) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (wr_en && !frame_end) state_d = ST_RUN_PEND;
            end
            ST_RUN_PEND: begin
                if (frame_end) state_d = ST_RUN;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        running   = 1'b0;
        direct_wr = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_HALT: direct_wr = wr_en;
            ST_RUN: begin
                running = 1'b1;
                commit  = frame_end && wr_en;
            end
            ST_RUN_PEND: begin
                running = 1'b1;
                commit  = frame_end;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/crtc_cfg_bank.sv
module crtc_cfg_bank
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              direct_wr,
    input  logic              commit,
    output timing_t           live_cfg
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] live_words;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic              hit;
        logic [WORD_W-1:0] shadow_r, live_r, shadow_nx;

        assign hit       = wr_en && (wr_sel == SEL_W'(i));
        assign shadow_nx = hit ? wr_data : shadow_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_r <= '0;
                live_r   <= '0;
            end else begin
                shadow_r <= shadow_nx;
                if (commit)
                    live_r <= shadow_nx;
                else if (direct_wr && hit)
                    live_r <= wr_data;
            end
        end

        assign live_words[i] = live_r;
    end

    assign live_cfg = unpack_timing(live_words);
endmodule

// File: rtl/crtc_scan_counters.sv
module crtc_scan_counters
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  timing_t           cfg,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              frame_end
);
    logic [PIX_W-1:0] hlast;
    logic             line_end, last_line;

    assign hlast     = {cfg.htot_ch, {CHAR_SHIFT{1'b1}}};
    assign line_end  = pix_cnt >= hlast;
    assign last_line = line_cnt >= cfg.vtot_m1;
    assign frame_end = running && line_end && last_line;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            pix_cnt  <= '0;
            line_cnt <= '0;
        end else if (line_end) begin
            pix_cnt  <= '0;
            line_cnt <= last_line ? '0 : line_cnt + 1'b1;
        end else begin
            pix_cnt  <= pix_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/crtc_sync_out.sv
module crtc_sync_out
    import crtc_pkg::*;
(
    input  logic              running,
    input  logic              dis_disp,
    input  logic              dis_h,
    input  logic              dis_v,
    input  timing_t           cfg,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    output logic              de,
    output logic              hsync,
    output logic              vsync
);
    localparam int HX_W = PIX_W + 1;
    localparam int VX_W = LINE_W + 1;

    logic [HX_W-1:0]  px, hs_lo, hs_hi;
    logic [VX_W-1:0]  ln, vs_lo, vs_hi;
    logic [PIX_W-1:0] hact_last;
    logic             in_h, in_v;

    assign px        = HX_W'(pix_cnt);
    assign hs_lo     = HX_W'(cfg.hs_start);
    assign hs_hi     = hs_lo + HX_W'(cfg.hs_wid);
    assign ln        = VX_W'(line_cnt);
    assign vs_lo     = VX_W'(cfg.vs_start_m1);
    assign vs_hi     = vs_lo + VX_W'(cfg.vs_wid);
    assign hact_last = PIX_W'({cfg.hact_ch, {CHAR_SHIFT{1'b1}}});

    assign in_h = (px >= hs_lo) && (px < hs_hi);
    assign in_v = (ln >= vs_lo) && (ln < vs_hi);

    assign de    = running && !dis_disp && (pix_cnt <= hact_last) && (line_cnt <= cfg.vact_m1);
    assign hsync = (running && in_h && !dis_h) ^ cfg.hs_neg;
    assign vsync = (running && in_v && !dis_v) ^ cfg.vs_neg;
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              display_off,
    input  logic              hsync_off,
    input  logic              vsync_off,
    output logic [PIX_W-1:0]  pix_x,
    output logic [LINE_W-1:0] line_y,
    output logic              de,
    output logic              hsync,
    output logic              vsync
);
    logic    running, direct_wr, commit, frame_end;
    timing_t live_cfg;

    crtc_load_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .frame_end (frame_end),
        .running   (running),
        .direct_wr (direct_wr),
        .commit    (commit)
    );

    crtc_cfg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .direct_wr (direct_wr),
        .commit    (commit),
        .live_cfg  (live_cfg)
    );

    crtc_scan_counters u_scan (
        .clk       (clk),
        .rst       (rst),
        .running   (running),
        .cfg       (live_cfg),
        .pix_cnt   (pix_x),
        .line_cnt  (line_y),
        .frame_end (frame_end)
    );

    crtc_sync_out u_sync (
        .running  (running),
        .dis_disp (display_off),
        .dis_h    (hsync_off),
        .dis_v    (vsync_off),
        .cfg      (live_cfg),
        .pix_cnt  (pix_x),
        .line_cnt (line_y),
        .de       (de),
        .hsync    (hsync),
        .vsync    (vsync)
    );
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
    import crtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              running,
    input logic              frame_end,
    input timing_t           cfg,
    input logic [PIX_W-1:0]  pix_x,
    input logic [LINE_W-1:0] line_y,
    input logic              de,
    input logic              hsync,
    input logic              vsync,
    input logic              display_off,
    input logic              hsync_off,
    input logic              vsync_off
);
    logic [PIX_W-1:0] hlast, hact_last;
    assign hlast     = {cfg.htot_ch, {CHAR_SHIFT{1'b1}}};
    assign hact_last = PIX_W'({cfg.hact_ch, {CHAR_SHIFT{1'b1}}});

    AST_HALT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !running |-> (pix_x == '0) && (line_y == '0) && !de); // R2
    AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
        running && (pix_x != hlast) |=> pix_x == PIX_W'($past(pix_x) + 1'b1)); // R3
    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (rst)
        running && (pix_x == hlast) |=> pix_x == '0); // R3
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        running && (pix_x == hlast) && (line_y != cfg.vtot_m1) |=> line_y == LINE_W'($past(line_y) + 1'b1)); // R4
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (line_y == '0) && (pix_x == '0)); // R4
    AST_DE_HBLANK: assert property (@(posedge clk) disable iff (rst)
        (pix_x > hact_last) |-> !de); // R5
    AST_DE_FORCED_OFF: assert property (@(posedge clk) disable iff (rst)
        display_off |-> !de); // R8
    AST_HSYNC_FORCED_IDLE: assert property (@(posedge clk) disable iff (rst)
        hsync_off |-> hsync == cfg.hs_neg); // R8
    AST_VSYNC_FORCED_IDLE: assert property (@(posedge clk) disable iff (rst)
        vsync_off |-> vsync == cfg.vs_neg); // R8
    AST_CFG_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        running && !frame_end |=> $stable(cfg)); // R9
endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .running     (running),
    .frame_end   (frame_end),
    .cfg         (live_cfg),
    .pix_x       (pix_x),
    .line_y      (line_y),
    .de          (de),
    .hsync       (hsync),
    .vsync       (vsync),
    .display_off (display_off),
    .hsync_off   (hsync_off),
    .vsync_off   (vsync_off)
);

// File: tb/tb_crtc_timing_gen.sv
module tb_crtc_timing_gen;
    import crtc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [SEL_W-1:0]  wr_sel = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              display_off = 1'b0;
    logic              hsync_off = 1'b0;
    logic              vsync_off = 1'b0;
    logic [PIX_W-1:0]  pix_x;
    logic [LINE_W-1:0] line_y;
    logic              de, hsync, vsync;

    crtc_timing_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .display_off(display_off), .hsync_off(hsync_off), .vsync_off(vsync_off),
        .pix_x(pix_x), .line_y(line_y), .de(de), .hsync(hsync), .vsync(vsync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string phase;
        int    px;
        int    ln;
        bit    de;
        bit    hs;
        bit    vs;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    // independent cycle model
    logic [31:0] m_live[4];
    logic [31:0] m_shadow[4];
    bit          m_run, m_pend;
    int          m_loaded, mx, my;
    string       phase = "";

    // next input values, applied by step()
    bit          n_wr = 0;
    logic [1:0]  n_sel = '0;
    logic [31:0] n_data = '0;
    bit          n_dd = 0, n_dh = 0, n_dv = 0;

    function automatic int hl();   return int'(m_live[0][9:0]) * 8 + 7; endfunction
    function automatic int hal();  return int'(m_live[0][24:16]) * 8 + 7; endfunction
    function automatic int vl();   return int'(m_live[2][15:0]); endfunction
    function automatic int val();  return int'(m_live[2][31:16]); endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_live[i] = '0;
            m_shadow[i] = '0;
        end
        m_run = 0; m_pend = 0; m_loaded = 0; mx = 0; my = 0;
    endtask

    task automatic model_edge();
        bit fe;
        fe = m_run && (mx == hl()) && (my == vl());
        if (!m_run) begin
            if (wr_en) begin
                m_live[wr_sel]   = wr_data;
                m_shadow[wr_sel] = wr_data;
                m_loaded = m_loaded | (1 << wr_sel);
                if (m_loaded == 15) m_run = 1;
            end
        end else begin
            if (wr_en) begin
                m_shadow[wr_sel] = wr_data;
                m_pend = 1;
            end
            if (mx >= hl()) begin
                mx = 0;
                if (my >= vl()) my = 0; else my = my + 1;
            end else begin
                mx = mx + 1;
            end
            if (fe && m_pend) begin
                for (int i = 0; i < 4; i++) m_live[i] = m_shadow[i];
                m_pend = 0;
            end
        end
    endtask

    function automatic exp_t expect_now();
        exp_t e;
        int   hss, hsw, vss, vsw;
        bit   hact, vact;
        hss = int'(m_live[1][12:0]);
        hsw = int'(m_live[1][21:16]);
        vss = int'(m_live[3][11:0]);
        vsw = int'(m_live[3][20:16]);
        hact = m_run && (mx >= hss) && (mx < hss + hsw);
        vact = m_run && (my >= vss) && (my < vss + vsw);
        e.phase = phase;
        e.px = mx;
        e.ln = my;
        e.de = m_run && !display_off && (mx <= hal()) && (my <= val());
        e.hs = (hact && !hsync_off) ^ m_live[1][23];
        e.vs = (vact && !vsync_off) ^ m_live[3][23];
        return e;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
        model_edge();
        wr_en = n_wr; wr_sel = n_sel; wr_data = n_data;
        n_wr = 0;
        display_off = n_dd; hsync_off = n_dh; vsync_off = n_dv;
        sbq.push_back(expect_now());
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic put(input logic [1:0] sel, input logic [31:0] data);
        n_wr = 1; n_sel = sel; n_data = data;
        step();
    endtask

    task automatic cmp(input string tag, input string name, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, name, act, exp_v, $time);
        end
    endtask

    // monitor: pops one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        exp_t e;
        if (sbq.size() != 0) begin
            e = sbq.pop_front();
            cmp((e.phase != "") ? e.phase : "R3", "pix_x",  int'(pix_x),  e.px);
            cmp((e.phase != "") ? e.phase : "R4", "line_y", int'(line_y), e.ln);
            cmp((e.phase != "") ? e.phase : "R5", "de",     int'(de),     int'(e.de));
            cmp((e.phase != "") ? e.phase : "R6", "hsync",  int'(hsync),  int'(e.hs));
            cmp((e.phase != "") ? e.phase : "R7", "vsync",  int'(vsync),  int'(e.vs));
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog act=%0d exp=0 cycles left", WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        phase = "R1";
        sbq.push_back(expect_now());
        steps(2);

        // R2: halted loading, counters held until all four words written
        phase = "R2";
        put(2'd0, 32'h0001_0003);   // 32-pixel lines, 16 active
        steps(3);
        put(2'd1, 32'h0084_0014);   // hsync at 20, 4 wide, active low
        put(2'd2, 32'h0005_0009);   // 10 lines, 6 active
        steps(3);
        put(2'd0, 32'h0001_0003);   // rewrite does not count twice
        steps(2);
        put(2'd3, 32'h0002_0007);   // vsync at line 7, 2 lines, active high

        // R3..R7: two full frames under the loaded timing
        phase = "";
        steps(640);

        // R8: each control input on its own for about a frame
        phase = "R8";
        n_dd = 1; steps(330);
        n_dd = 0; n_dh = 1; steps(330);
        n_dh = 0; n_dv = 1; steps(330);
        n_dv = 0; steps(5);

        // R9: mid-frame writes deferred, last write wins
        phase = "R9";
        steps(50);
        put(2'd0, 32'h0002_0004);   // 40-pixel lines, 24 active
        put(2'd3, 32'h0083_0006);   // vsync at line 6, 3 lines, active low
        put(2'd2, 32'h0005_0007);
        steps(20);
        put(2'd2, 32'h0005_000B);   // supersedes: 12 lines
        steps(700);

        // R9: write captured on the frame-end edge joins that commit
        while (!(m_run && (mx == hl() - 1) && (my == vl()))) step();
        put(2'd1, 32'h0000_0019);   // hsync at 25, width 0: never asserts
        steps(600);

        @(negedge clk);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule